// File: doc/BRIEF.md
# Priority Sector Block DMA Scheduler

This block moves sectors from an optical-disc byte stream into a memory window that is split into fixed-size slots, one slot per bit of a 16-bit pending mask. Software sets bits in the mask. For each incoming sector the scheduler picks the highest pending bit and writes one formatted block into that slot. It then clears the bit and pulses a block-complete interrupt. Reading the mask shows which slots are still waiting.

Each block has a fixed layout. It opens with three zero bytes and a byte holding the low five bits of the sector number. The sector's raw bytes follow, minus the first four. The correction bytes sit at a fixed offset within the slot. Each stream byte produces one memory write, so the block needs no buffering. The four skipped raw bytes arrive in the same cycles as the four header writes. When no slot is pending, a sector is dropped and an overflow pulse is raised. While the data-DMA enable is low, sectors are ignored.

Top module: `sector_slot_dma`

## Requirements
- R1: After reset the pending mask reads zero, and no memory write, block interrupt or overflow pulse occurs until a sector is offered.
- R2: Every write goes to address {win_base, slot, offset}: win_base fills the bits above the window, the slot index takes the next log2(SLOTS) bits, and the byte offset within the slot takes the low SLOT_AW bits.
- R3: When a sector starts, the scheduler picks the highest set bit of the pending mask as the target slot (bit SLOTS-1 first, then downward).
- R4: One cycle after the last byte of a stored sector, the target bit reads 0 in slot_mask and blk_irq is high for exactly one cycle.
- R5: Offsets 0, 1 and 2 of a block are written as 0x00. Offset 3 is written as {3'b000, sec_tag}, where sec_tag is sampled on the sector's first byte.
- R6: Raw stream bytes 4 to 4+DATA_LEN-1 are written at the offset equal to their index, and raw bytes 0 to 3 are never stored. A stored sector makes exactly 4+DATA_LEN+ECC_LEN writes.
- R7: The ECC_LEN correction bytes, which follow the raw bytes in the stream, are written at offsets ECC_OFF+j.
- R8: A mask write ORs mask_wdata into the pending mask and never clears a bit. Each mask write gives a one-cycle txdone_clr pulse in the following cycle.
- R9: A sector that starts while dma_en is low causes no write, no interrupt and no change to the mask.
- R10: A sector that starts while dma_en is high and the mask is zero causes no write, and ovf_irq is high for exactly one cycle.
- R11: A bit written while a sector is in progress does not redirect that sector. The current block completes in its slot, and the new bit is served by a later sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | Data-DMA enable from the configuration register |
| win_base | input | AW-WIN_AW | Address bits above the slot window (the window is aligned) |
| mask_wr | input | 1 | Pending-mask write strobe |
| mask_wdata | input | SLOTS | Bits to OR into the pending mask |
| slot_mask | output | SLOTS | Live pending mask |
| txdone_clr | output | 1 | Pulse that clears the command-transmit-done request |
| s_valid | input | 1 | Stream byte valid |
| s_first | input | 1 | Marks the first byte of a sector |
| s_data | input | 8 | Stream byte: raw sector bytes, then correction bytes |
| sec_tag | input | 5 | Low bits of the sector number, sampled with the first byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Byte address of the write |
| mem_data | output | 8 | Byte written |
| blk_irq | output | 1 | Block-complete interrupt pulse |
| ovf_irq | output | 1 | Sector-dropped (overflow) pulse |

## Verification
The bench builds the block with 4 slots of 64 bytes each, 20 data bytes and 6 correction bytes at offset 32, in a 16-bit address space. With these values a sector is only 30 bytes long, so every one of the 15 non-zero mask patterns can be drained completely in a short run. Each drained block is compared byte by byte against values computed from the sector number. The small configuration also makes it cheap to cover the drop case, the disabled case and a mask write in the middle of a sector.

// File: rtl/sector_slot_dma.sv
module sector_slot_dma #(
  parameter int SLOTS    = 16,
  parameter int SLOT_AW  = 12,
  parameter int DATA_LEN = 2348,
  parameter int ECC_OFF  = 'hC00,
  parameter int ECC_LEN  = 146,
  parameter int AW       = 32,
  localparam int SW      = $clog2(SLOTS),
  localparam int WIN_AW  = SLOT_AW + SW
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dma_en,
  input  logic [AW-WIN_AW-1:0] win_base,
  input  logic                 mask_wr,
  input  logic [SLOTS-1:0]     mask_wdata,
  output logic [SLOTS-1:0]     slot_mask,
  output logic                 txdone_clr,
  input  logic                 s_valid,
  input  logic                 s_first,
  input  logic [7:0]           s_data,
  input  logic [4:0]           sec_tag,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [7:0]           mem_data,
  output logic                 blk_irq,
  output logic                 ovf_irq
);
  localparam int RAW_LEN = 4 + DATA_LEN;
  localparam int TOTAL   = RAW_LEN + ECC_LEN;
  localparam int CW      = $clog2(TOTAL + 1);

  logic          busy, keep;
  logic [CW-1:0] cnt;
  logic [SW-1:0] cur, top;
  logic [4:0]    tag;

  always_comb begin
    top = '0;
    for (int i = 0; i < SLOTS; i++)
      if (slot_mask[i]) top = SW'(i);
  end

  wire start = s_valid && s_first && !busy;
  wire go    = dma_en && |slot_mask;
  wire take  = start || (s_valid && busy);
  wire store = start ? go : (take && keep);
  wire [CW-1:0] idx = start ? '0 : cnt;
  wire last  = take && (idx == CW'(TOTAL - 1));
  wire [SW-1:0] slot = start ? top : cur;
  wire [4:0] tag_now = start ? sec_tag : tag;
  wire [SLOT_AW-1:0] off = (idx < CW'(RAW_LEN)) ? SLOT_AW'(idx)
                         : SLOT_AW'(ECC_OFF) + SLOT_AW'(idx - CW'(RAW_LEN));
  wire [7:0] byte_out = (idx < CW'(3)) ? 8'h00 : (idx == CW'(3)) ? {3'b000, tag_now} : s_data;
  wire [SLOTS-1:0] clr = (store && last) ? (SLOTS'(1) << slot) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_mask  <= '0;
      txdone_clr <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_data   <= '0;
      blk_irq    <= 1'b0;
      ovf_irq    <= 1'b0;
      busy       <= 1'b0;
      keep       <= 1'b0;
      cnt        <= '0;
      cur        <= '0;
      tag        <= '0;
    end else begin
      slot_mask  <= (slot_mask & ~clr) | (mask_wr ? mask_wdata : '0);
      txdone_clr <= mask_wr;
      mem_we     <= store;
      mem_addr   <= {win_base, slot, off};
      mem_data   <= byte_out;
      blk_irq    <= store && last;
      ovf_irq    <= start && dma_en && !(|slot_mask);
      if (take) begin
        cnt  <= idx + 1'b1;
        busy <= !last;
      end
      if (start) begin
        keep <= go;
        cur  <= top;
        tag  <= sec_tag;
      end
    end
  end

  // R3
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && go |=> ((($past(slot_mask) >> cur) >> 1) == '0));

  // R4
  blk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_irq && !$past(mask_wr) |-> !slot_mask[$past(cur)]);

  // R5
  hdr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && (mem_addr[SLOT_AW-1:0] < SLOT_AW'(3)) |-> mem_data == 8'h00);

  // R10
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> $past(dma_en) && ($past(slot_mask) == '0) && !mem_we);

  // R4
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({blk_irq, ovf_irq}));

  // R8
  txc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_wr) |-> ((slot_mask & $past(mask_wdata)) == $past(mask_wdata)));
endmodule

// File: tb/sector_slot_dma_tb.sv
`timescale 1ns/1ps
module sector_slot_dma_tb;
  localparam int SLOTS = 4, SLOT_AW = 6, DATA_LEN = 20, ECC_OFF = 32, ECC_LEN = 6, AW = 16;
  localparam int RAW_LEN = 4 + DATA_LEN;
  localparam int TOTAL = RAW_LEN + ECC_LEN;
  localparam logic [7:0] WIN = 8'h34;

  logic clk = 0, rst_n = 0, dma_en = 0, mask_wr = 0, s_valid = 0, s_first = 0;
  logic [3:0] mask_wdata = '0;
  logic [7:0] s_data = '0;
  logic [4:0] sec_tag = '0;
  wire [3:0] slot_mask;
  wire txdone_clr, mem_we, blk_irq, ovf_irq;
  wire [15:0] mem_addr;
  wire [7:0] mem_data;

  int checks = 0, fails = 0, nwr = 0, aerr = 0, nblk = 0, novf = 0, ntxc = 0;
  logic [7:0] sh [0:255];

  always #5 clk = ~clk;

  sector_slot_dma #(.SLOTS(SLOTS), .SLOT_AW(SLOT_AW), .DATA_LEN(DATA_LEN), .ECC_OFF(ECC_OFF),
                    .ECC_LEN(ECC_LEN), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .win_base(WIN), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .slot_mask(slot_mask), .txdone_clr(txdone_clr),
    .s_valid(s_valid), .s_first(s_first), .s_data(s_data), .sec_tag(sec_tag),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .blk_irq(blk_irq), .ovf_irq(ovf_irq));

  always @(negedge clk) begin
    if (mem_we) begin
      nwr++;
      if (mem_addr[15:8] != WIN) aerr++;
      sh[mem_addr[7:0]] = mem_data;
    end
    if (blk_irq) nblk++;
    if (ovf_irq) novf++;
    if (txdone_clr) ntxc++;
  end

  function automatic logic [7:0] raw_b(int sn, int i);
    return 8'(sn * 7 + i * 3);
  endfunction
  function automatic logic [7:0] ecc_b(int sn, int j);
    return 8'hA0 ^ 8'(j) ^ 8'(sn);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wipe();
    for (int a = 0; a < 256; a++) sh[a] = 8'hEE;
  endtask

  task automatic wrmask(logic [3:0] m);
    mask_wr = 1; mask_wdata = m;
    @(negedge clk);
    mask_wr = 0;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic send(int sn, int midpos, logic [3:0] midmask);
    for (int i = 0; i < TOTAL; i++) begin
      s_valid = 1; s_first = (i == 0); sec_tag = 5'(sn);
      s_data = (i < RAW_LEN) ? raw_b(sn, i) : ecc_b(sn, i - RAW_LEN);
      mask_wr = (i == midpos); mask_wdata = midmask;
      @(negedge clk);
    end
    s_valid = 0; s_first = 0; mask_wr = 0;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic check_block(int slot, int sn);
    for (int o = 0; o < 3; o++) chk("R5 hdr zero", sh[slot*64+o], 0);
    chk("R5 tag", sh[slot*64+3], sn % 32);
    for (int o = 4; o < RAW_LEN; o++) chk("R6 raw", sh[slot*64+o], raw_b(sn, o));
    for (int j = 0; j < ECC_LEN; j++) chk("R7 ecc", sh[slot*64+ECC_OFF+j], ecc_b(sn, j));
  endtask

  // stores one sector and checks slot, mask and interrupt
  task automatic serve(int sn, int slot, logic [3:0] exp_mask, int midpos, logic [3:0] midmask);
    int w0, k0;
    wipe(); w0 = nwr; k0 = nblk;
    send(sn, midpos, midmask);
    chk("R6 write count", nwr - w0, TOTAL);
    chk("R4 mask after block", slot_mask, exp_mask);
    chk("R4 one blk_irq", nblk - k0, 1);
    check_block(slot, sn);
  endtask

  initial begin
    int t0, w0, k0, o0;
    logic [3:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 mask reset", slot_mask, 0);
    chk("R1 no writes", nwr, 0);
    chk("R1 no irq", nblk + novf, 0);
    dma_en = 1;

    for (int m = 1; m < 16; m++) begin
      t0 = ntxc;
      wrmask(4'(m));
      chk("R8 txdone_clr pulse", ntxc - t0, 1);
      chk("R8 mask set", slot_mask, m);
      exp = 4'(m);
      for (int s = 3; s >= 0; s--) begin
        if (exp[s]) begin
          exp[s] = 1'b0;
          serve(37 + m * 5 + s, s, exp, -1, 4'h0);  // R3 highest bit served first
        end
      end
    end

    w0 = nwr; o0 = novf;
    send(90, -1, 4'h0);
    chk("R10 ovf pulse", novf - o0, 1);
    chk("R10 no writes", nwr - w0, 0);

    dma_en = 0;
    wrmask(4'b0101);
    w0 = nwr; o0 = novf; k0 = nblk;
    send(91, -1, 4'h0);
    chk("R9 no writes", nwr - w0, 0);
    chk("R9 mask kept", slot_mask, 5);
    chk("R9 no irq", (nblk - k0) + (novf - o0), 0);
    dma_en = 1;
    serve(92, 2, 4'b0001, -1, 4'h0);
    serve(93, 0, 4'b0000, -1, 4'h0);

    wrmask(4'b1000);
    wrmask(4'b0010);
    chk("R8 OR while idle", slot_mask, 10);
    serve(94, 3, 4'b0010, -1, 4'h0);
    serve(95, 1, 4'b0000, -1, 4'h0);

    wrmask(4'b0001);
    serve(96, 0, 4'b1000, 10, 4'b1000);  // R11 current block finishes in slot 0
    serve(97, 3, 4'b0000, -1, 4'h0);     // R11 new bit served next

    chk("R2 window address", aerr, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule